// File: doc/BRIEF.md
# Section Parity Generator and Inserter

This block sits in the transmit path of a byte-serial line framer, just ahead of the scrambler. It computes an 8-bit bit-interleaved even parity over every byte of one frame as the bytes leave the scrambler. It then writes that value, unscrambled, into the section parity byte of the next frame. Frames are `ROWS` rows of `ROW_BYTES` bytes each, and one byte is presented per clock. The parity slots are the first `SLOTS` byte positions of the second row. Only the first slot carries the parity. The others are forced to zero.

Two frame-start pulses keep the two streams separate. One marks the first byte of the pre-scramble stream entering the block. The other marks the first byte of the scrambled stream fed back into it. This lets the scrambler have any pipeline latency. For fault testing, an 8-bit mask can invert chosen parity bits, but only while the fault enable is high. Every other byte passes through with one register of delay.

Top module: `bip_insert`

## Requirements
- R1: `dout` equals `din` one clock later for every byte that is not a parity slot.
- R2: The byte carrying `sof_i` is position 0. Positions then count up by one per clock and wrap from `ROWS*ROW_BYTES-1` to 0 without a new pulse.
- R3: At position `ROW_BYTES`, `dout` carries the parity. Bit i of the parity is the XOR of bit i of every `fb_byte`, starting with the one marked by `fb_sof` and ending with the one just before the next `fb_sof`. The parity is latched at that next `fb_sof`.
- R4: Positions `ROW_BYTES+1` to `ROW_BYTES+SLOTS-1` are output as 0x00.
- R5: With `fault_en`=1, the inserted parity is XORed with `force_mask`. With `fault_en`=0, `force_mask` has no effect on any output byte.
- R6: The parity value is 0x00 until a complete feedback frame has been accumulated, meaning the span from the first `fb_sof` after reset to the second.
- R7: After reset and before the first `sof_i`, no byte is replaced and all bytes pass through.
- R8: During reset, `dout` and `sof_o` are 0.
- R9: A `sof_i` that arrives before a frame is complete restarts the position count at 0.
- R10: `sof_o` equals `sof_i` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Marks the first byte of a pre-scramble frame |
| din | input | 8 | Pre-scramble byte stream |
| fb_sof | input | 1 | Marks the first byte of a scrambled frame on the feedback |
| fb_byte | input | 8 | Scrambled byte stream fed back |
| force_mask | input | 8 | Parity bits to invert during fault insertion |
| fault_en | input | 1 | Enables the parity inversion |
| dout | output | 8 | Pre-scramble stream with the parity slots filled |
| sof_o | output | 1 | Frame start aligned to `dout` |

## Verification
The hardest cases to reach are the frame boundaries. These include the first frames after reset, where the parity must still read zero, and a feedback pulse that does not line up with the forward pulse. They also include a frame cut short by an early start pulse, and a long run with no pulse, which must wrap. The bench uses a small frame geometry so that many frames fit into one run. It moves through directed phases (an aligned start-up, an offset feedback pulse, a short frame, a missing pulse) while `din`, `fb_byte`, the mask and the fault enable take seeded random values. A reference model built from the requirements predicts every output byte.

// File: rtl/bip_pkg.sv
package bip_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/bip_accum.sv
module bip_accum
  import bip_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fb_sof,
  input  byte_t fb_byte,
  output byte_t par
);
  byte_t acc;
  logic  started;
  logic  par_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      started <= 1'b0;
      par     <= '0;
      par_ok  <= 1'b0;
    end else if (fb_sof) begin
      acc     <= fb_byte;
      started <= 1'b1;
      if (started) begin
        par    <= acc;
        par_ok <= 1'b1;
      end
    end else begin
      acc <= acc ^ fb_byte;
    end
  end

  a_r3_par_held: assert property (@(posedge clk) disable iff (rst)
    !fb_sof |=> $stable(par));
  a_r6_zero_until_full: assert property (@(posedge clk) disable iff (rst)
    !par_ok |-> par == 8'h00);
endmodule

// File: rtl/bip_frame_pos.sv
module bip_frame_pos #(
  parameter int ROW_BYTES = 1080,
  parameter int ROWS      = 9,
  parameter int SLOTS     = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  output logic is_par,
  output logic is_zero
);
  localparam int FRAME = ROW_BYTES * ROWS;
  localparam int CW    = $clog2(FRAME);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cur;
  logic          aligned;
  logic          active;

  assign active = sof_i | aligned;

  always_comb begin
    if (sof_i)                       cur = '0;
    else if (cnt == CW'(FRAME - 1))  cur = '0;
    else                             cur = cnt + 1'b1;
  end

  assign is_par = active && (cur == CW'(ROW_BYTES));

  generate
    if (SLOTS > 1) begin : g_zero
      assign is_zero = active && (cur > CW'(ROW_BYTES)) &&
                       (cur < CW'(ROW_BYTES + SLOTS));
    end else begin : g_nozero
      assign is_zero = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= CW'(FRAME - 1);
      aligned <= 1'b0;
    end else if (active) begin
      cnt     <= cur;
      aligned <= 1'b1;
    end
  end

  a_r4_slot_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_par, is_zero}));
  a_r2_pos_range: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(FRAME));
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    sof_i |=> cnt == '0);
endmodule

// File: rtl/bip_insert.sv
module bip_insert
  import bip_pkg::*;
#(
  parameter int ROW_BYTES = 1080,
  parameter int ROWS      = 9,
  parameter int SLOTS     = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sof_i,
  input  logic [7:0] din,
  input  logic       fb_sof,
  input  logic [7:0] fb_byte,
  input  logic [7:0] force_mask,
  input  logic       fault_en,
  output logic [7:0] dout,
  output logic       sof_o
);
  byte_t par;
  byte_t ins;
  logic  is_par;
  logic  is_zero;

  bip_accum u_accum (
    .clk     (clk),
    .rst     (rst),
    .fb_sof  (fb_sof),
    .fb_byte (fb_byte),
    .par     (par)
  );

  bip_frame_pos #(
    .ROW_BYTES (ROW_BYTES),
    .ROWS      (ROWS),
    .SLOTS     (SLOTS)
  ) u_pos (
    .clk     (clk),
    .rst     (rst),
    .sof_i   (sof_i),
    .is_par  (is_par),
    .is_zero (is_zero)
  );

  assign ins = par ^ (fault_en ? force_mask : 8'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      sof_o <= 1'b0;
    end else begin
      sof_o <= sof_i;
      if (is_par)       dout <= ins;
      else if (is_zero) dout <= '0;
      else              dout <= din;
    end
  end

  a_r1_sof_passthrough: assert property (@(posedge clk) disable iff (rst)
    sof_i |=> dout == $past(din));
  a_r8_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (dout == 8'h00 && !sof_o));
endmodule

// File: tb/tb_bip_insert.sv
module tb_bip_insert;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 20;
  localparam int RW = 4;
  localparam int SL = 12;
  localparam int FR = RB * RW;

  logic       clk = 1'b0;
  logic       rst;
  logic       sof_i, fb_sof, fault_en;
  logic [7:0] din, fb_byte, force_mask;
  logic [7:0] dout;
  logic       sof_o;

  int checks = 0;
  int fails  = 0;

  bip_insert #(.ROW_BYTES(RB), .ROWS(RW), .SLOTS(SL)) dut (
    .clk(clk), .rst(rst), .sof_i(sof_i), .din(din), .fb_sof(fb_sof),
    .fb_byte(fb_byte), .force_mask(force_mask), .fault_en(fault_en),
    .dout(dout), .sof_o(sof_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int         m_cnt = FR - 1;
  bit         m_aligned = 0;
  logic [7:0] m_acc = 0, m_par = 0;
  bit         m_started = 0;
  int         m_fbpos = 0;
  logic [7:0] exp_out;
  bit         exp_sof;
  bit         exp_valid = 0;
  string      exp_tag;

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_out(bit f, logic [7:0] d, logic [7:0] m,
                                           bit fe, output string t, input string ph);
    int cur;
    if (!(f || m_aligned)) begin t = ph; return d; end
    cur = f ? 0 : (m_cnt == FR - 1 ? 0 : m_cnt + 1);
    if (cur == RB) begin
      t = (!m_started || m_par == 0 && fe == 0) ? (fe ? "R5" : "R6") : (fe ? "R5" : "R3");
      return m_par ^ (fe ? m : 8'h00);
    end
    if (cur > RB && cur < RB + SL) begin t = "R4"; return 8'h00; end
    t = ph;
    return d;
  endfunction

  task automatic step(bit f, bit ff, logic [7:0] d, logic [7:0] fb,
                      logic [7:0] m, bit fe, string ph);
    string t;
    if (exp_valid) begin
      check(exp_tag, {1'b0, dout}, {1'b0, exp_out});
      check("R10", {8'h00, sof_o}, {8'h00, exp_sof});
    end
    sof_i = f; fb_sof = ff; din = d; fb_byte = fb; force_mask = m; fault_en = fe;
    exp_out = model_out(f, d, m, fe, t, ph);
    exp_tag = t;
    exp_sof = f;
    exp_valid = 1;
    if (f || m_aligned) begin
      m_cnt = f ? 0 : (m_cnt == FR - 1 ? 0 : m_cnt + 1);
      m_aligned = 1;
    end
    if (ff) begin
      if (m_started) m_par = m_acc;
      m_acc = fb;
      m_started = 1;
    end else begin
      m_acc = m_acc ^ fb;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_frame(int len, int fboff, bit send_sof, string ph);
    logic [7:0] msk = 8'($urandom);
    bit fe = 1'($urandom);
    for (int i = 0; i < len; i++)
      step(send_sof && i == 0, i == fboff, 8'($urandom), 8'($urandom), msk, fe, ph);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; sof_i = 0; fb_sof = 0; din = 8'hA5; fb_byte = 0;
    force_mask = 8'hFF; fault_en = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R8", {sof_o, dout}, 9'h000);
    rst = 0;
    // R7: no alignment yet, passthrough
    for (int i = 0; i < RB + 15; i++)
      step(0, 0, 8'($urandom), 8'($urandom), 8'hFF, 1, "R7");
    // R6: first frames, parity must read zero (mask off)
    step(1, 1, 8'h11, 8'h3C, 8'hFF, 0, "R1");
    for (int i = 1; i < FR; i++) step(0, 0, 8'($urandom), 8'($urandom), 8'hFF, 0, "R1");
    // aligned random frames (R3, R5)
    for (int k = 0; k < 20; k++) run_frame(FR, 0, 1, "R1");
    // feedback pulse offset from forward pulse
    for (int k = 0; k < 10; k++) run_frame(FR, 5, 1, "R1");
    // R9: short frame
    run_frame(RB + 3, 0, 1, "R9");
    for (int k = 0; k < 4; k++) run_frame(FR, 0, 1, "R9");
    // R2: no forward pulse, counter must wrap
    run_frame(FR, 0, 1, "R2");
    run_frame(FR, 0, 0, "R2");
    run_frame(FR, 0, 0, "R2");
    // R5: directed all-ones mask, then disabled
    for (int i = 0; i < FR; i++) step(i == 0, i == 0, 8'($urandom), 8'($urandom), 8'hFF, 1, "R5");
    for (int i = 0; i < FR; i++) step(i == 0, i == 0, 8'($urandom), 8'($urandom), 8'hFF, 0, "R5");
    step(0, 0, 8'h00, 8'h00, 8'h00, 0, "R1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule